// File: doc/BRIEF.md
# BCD Calendar Real-Time Clock with Full-Match Alarm

This block keeps wall-clock time in packed BCD. A one-cycle `tick` strobe, one per period of the 32.768 kHz oscillator, drives a prescaler. Each time the prescaler completes a second, the calendar advances by one second. Seconds, minutes, hours, day of month, month, two-digit year and a 0–6 weekday all ripple forward together. The day rollover follows each month's length, and February grows to 29 days in years divisible by four.

Software reaches the block through a byte-wide register port whose registers sit on 4-byte strides. A run bit starts and freezes counting. A status byte reports power-up, alarm, per-second, per-minute, per-hour and per-day events, whether the clock is running, and a busy indication. The busy bit is raised for the last oscillator period before every one-second update, and software waits for it to drop before touching the time. An alarm compares six time fields exactly, with no field masked, and is raised in status when all of them agree. Two interrupt lines are driven: a per-second timer pulse and a level alarm request, each gated by its own enable bit.

Top module: `rtc_bcd_calendar`

## Requirements
- R1: After reset the time reads 00:00:00, day 01, month 01, year 00, weekday 0. Control and interrupt-enable read 0x00, status reads 0x80 (only the power-up flag), and both interrupt outputs are low.
- R2: Control bit 0 set lets the calendar count, and clear freezes it. Status bit 1 mirrors it. Every other control bit reads 0, including bit 7 after a write of 1.
- R3: With the clock running, the seconds advance once every TICKS_PER_SEC ticks. Status bit 0 (busy) is 1 exactly while running with the prescaler on the final tick of the second.
- R4: Seconds and minutes wrap 59→00 and hours wrap 23→00 in BCD, each wrap carrying into the next field.
- R5: The day wraps to 01 after day 31 in months 1, 3, 5, 7, 8, 10 and 12, after day 30 in months 4, 6, 9 and 11, and after day 28 in February, or day 29 when the year is divisible by 4 (year 00 included).
- R6: Month wraps 12→01 and carries into the year, and the year wraps 99→00.
- R7: The weekday register (3 bits) increments on every day rollover and wraps 6→0.
- R8: Status bit 6 is set one clock after a one-second update only when seconds, minutes, hours, day, month and year all equal their alarm registers. A mismatch in any single field leaves it clear.
- R9: Writing 1 to status bit 7 or bit 6 clears that flag. Writing 0 leaves it unchanged.
- R10: Status bits 2, 3, 4 and 5 report, for the most recent update, a new second, a seconds wrap, a minutes wrap and an hours wrap. They hold until the next update.
- R11: `irq_timer` is a one-clock pulse one clock after each update while interrupt-enable bit 2 is set. No pulse occurs when the bit is clear or the clock is stopped.
- R12: `irq_alarm` is high while status bit 6 is set and interrupt-enable bit 3 is set.
- R13: The register offsets are 0x00 seconds, 0x04 minutes, 0x08 hours, 0x0C day, 0x10 month, 0x14 year, 0x18 weekday, 0x20–0x34 the alarm fields in the same order, 0x40 control, 0x44 status and 0x48 interrupt-enable. Any other address reads 0x00 and ignores writes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | One-cycle strobe per oscillator period |
| bus_addr | input | ADDR_W | Register byte address |
| bus_we | input | 1 | Write strobe, sampled at the clock edge |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for `bus_addr`, combinational |
| irq_timer | output | 1 | Per-second interrupt pulse |
| irq_alarm | output | 1 | Alarm interrupt level |

## Verification
The bench runs a small prescaler and sweeps every month end of several leap and non-leap years, starting from both the last day and the day before it. If month lengths or the leap rule were wrong, this sweep would catch the day landing on 29, 31 or 01 at the wrong point. A second-by-second run across a February-to-March boundary is checked against an arithmetic model of every field, the weekday and the event flags, so a missing carry or an event flag that is not held shows up there. The alarm is driven with six near misses, each differing in exactly one field, before a true match. A compare that skipped a field would raise the alarm on a near miss. The busy window, the timer pulse width and the write-one-to-clear flags are checked at the exact cycles they should change.

// File: rtl/rtc_pkg.sv
package rtc_pkg;

   localparam int unsigned NUM_ALM_FIELDS = 6;

   // field slots in the alarm/compare vector; slot 0 is seconds
   localparam int unsigned F_SEC  = 0;
   localparam int unsigned F_MIN  = 1;
   localparam int unsigned F_HOUR = 2;
   localparam int unsigned F_DAY  = 3;
   localparam int unsigned F_MON  = 4;
   localparam int unsigned F_YEAR = 5;

   localparam logic [7:0] OFS_SEC      = 8'h00;
   localparam logic [7:0] OFS_MIN      = 8'h04;
   localparam logic [7:0] OFS_HOUR     = 8'h08;
   localparam logic [7:0] OFS_DAY      = 8'h0C;
   localparam logic [7:0] OFS_MON      = 8'h10;
   localparam logic [7:0] OFS_YEAR     = 8'h14;
   localparam logic [7:0] OFS_WDAY     = 8'h18;
   localparam logic [7:0] OFS_ALM_SEC  = 8'h20;
   localparam logic [7:0] OFS_ALM_MIN  = 8'h24;
   localparam logic [7:0] OFS_ALM_HOUR = 8'h28;
   localparam logic [7:0] OFS_ALM_DAY  = 8'h2C;
   localparam logic [7:0] OFS_ALM_MON  = 8'h30;
   localparam logic [7:0] OFS_ALM_YEAR = 8'h34;
   localparam logic [7:0] OFS_CTRL     = 8'h40;
   localparam logic [7:0] OFS_STATUS   = 8'h44;
   localparam logic [7:0] OFS_IRQEN    = 8'h48;

   typedef struct packed {
      logic [7:0] sec;
      logic [7:0] min;
      logic [7:0] hour;
      logic [7:0] day;
      logic [7:0] mon;
      logic [7:0] year;
      logic [2:0] wday;
   } rtc_time_t;

   localparam rtc_time_t TIME_RST = '{sec: 8'h00, min: 8'h00, hour: 8'h00,
                                      day: 8'h01, mon: 8'h01, year: 8'h00,
                                      wday: 3'd0};

   // add one to a two-digit packed BCD value
   function automatic logic [7:0] bcd_inc(input logic [7:0] v);
      logic [7:0] r;
      if (v[3:0] >= 4'd9) r = {v[7:4] + 4'd1, 4'h0};
      else                r = {v[7:4], v[3:0] + 4'd1};
      return r;
   endfunction

   function automatic logic [7:0] bcd_to_bin(input logic [7:0] v);
      return ({4'd0, v[7:4]} * 8'd10) + {4'd0, v[3:0]};
   endfunction

   // last day of a month, in BCD; leap when the binary year is a multiple of 4
   function automatic logic [7:0] month_last_day(input logic [7:0] mon,
                                                 input logic [7:0] year);
      logic [7:0] ybin;
      logic [7:0] r;
      ybin = bcd_to_bin(year);
      case (mon)
         8'h02:                      r = (ybin[1:0] == 2'b00) ? 8'h29 : 8'h28;
         8'h04, 8'h06, 8'h09, 8'h11: r = 8'h30;
         default:                    r = 8'h31;
      endcase
      return r;
   endfunction

endpackage

// File: rtl/rtc_prescaler.sv
module rtc_prescaler #(
   parameter int unsigned DIV = 32768
) (
   input  logic clk,
   input  logic rst_n,
   input  logic tick,
   input  logic run,
   output logic busy,
   output logic roll
);

   localparam int unsigned PW   = (DIV > 2) ? $clog2(DIV) : 1;
   localparam bit          POW2 = ((DIV & (DIV - 1)) == 0);

   logic [PW-1:0] cnt;
   logic          last;

   generate
      if (POW2) begin : g_pow2
         // counter wraps on its own; final tick is all ones
         assign last = &cnt;
      end else begin : g_cmp
         assign last = (cnt == PW'(DIV - 1));
      end
   endgenerate

   assign busy = run && last;
   assign roll = tick && run && last;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt <= '0;
      end else if (tick && run) begin
         cnt <= last ? '0 : cnt + 1'b1;
      end
   end

endmodule

// File: rtl/rtc_cal_next.sv
module rtc_cal_next
   import rtc_pkg::*;
(
   input  rtc_time_t cur,
   output rtc_time_t nxt,
   output logic      wrap_sec,
   output logic      wrap_min,
   output logic      wrap_hour
);

   logic [7:0] last_day;
   logic       wrap_day;
   logic       wrap_mon;

   always_comb begin
      last_day  = month_last_day(cur.mon, cur.year);

      wrap_sec  = (cur.sec >= 8'h59);
      wrap_min  = wrap_sec && (cur.min >= 8'h59);
      wrap_hour = wrap_min && (cur.hour >= 8'h23);
      wrap_day  = wrap_hour && (cur.day >= last_day);
      wrap_mon  = wrap_day && (cur.mon >= 8'h12);

      nxt      = cur;
      nxt.sec  = wrap_sec ? 8'h00 : bcd_inc(cur.sec);
      if (wrap_sec)  nxt.min  = wrap_min  ? 8'h00 : bcd_inc(cur.min);
      if (wrap_min)  nxt.hour = wrap_hour ? 8'h00 : bcd_inc(cur.hour);
      if (wrap_hour) begin
         nxt.day  = wrap_day ? 8'h01 : bcd_inc(cur.day);
         nxt.wday = (cur.wday >= 3'd6) ? 3'd0 : cur.wday + 3'd1;
      end
      if (wrap_day)  nxt.mon  = wrap_mon ? 8'h01 : bcd_inc(cur.mon);
      if (wrap_mon)  nxt.year = (cur.year >= 8'h99) ? 8'h00 : bcd_inc(cur.year);
   end

endmodule

// File: rtl/rtc_alarm_cmp.sv
module rtc_alarm_cmp #(
   parameter int unsigned NF = 6
) (
   input  logic [NF-1:0][7:0] now_f,
   input  logic [NF-1:0][7:0] alm_f,
   output logic               match
);

   logic [NF-1:0] eq;

   generate
      for (genvar i = 0; i < NF; i++) begin : g_field
         assign eq[i] = (now_f[i] == alm_f[i]);
      end
   endgenerate

   assign match = &eq;

endmodule

// File: rtl/rtc_bcd_calendar.sv
module rtc_bcd_calendar
   import rtc_pkg::*;
#(
   parameter int unsigned TICKS_PER_SEC = 32768,
   parameter int unsigned ADDR_W        = 7
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic              bus_we,
   input  logic [7:0]        bus_wdata,
   output logic [7:0]        bus_rdata,
   output logic              irq_timer,
   output logic              irq_alarm
);

   localparam int unsigned NF = NUM_ALM_FIELDS;

   generate
      if (TICKS_PER_SEC < 2) begin : g_bad_div
         $error("rtc_bcd_calendar: TICKS_PER_SEC must be 2 or more");
      end
      if (ADDR_W < 7) begin : g_bad_aw
         $error("rtc_bcd_calendar: ADDR_W must cover offset 0x48");
      end
   endgenerate

   rtc_time_t          cur;
   rtc_time_t          nxt;
   logic [NF-1:0][7:0] now_f;
   logic [NF-1:0][7:0] alm_f;
   logic               ctrl_run;
   logic               ie_alarm;
   logic               ie_timer;
   logic               st_pwr;
   logic               st_alm;
   logic [3:0]         ev_q;
   logic               upd_q;
   logic               busy;
   logic               roll;
   logic               match;
   logic               ev_min;
   logic               ev_hour;
   logic               ev_day;
   logic               hit_status;

   rtc_prescaler #(.DIV(TICKS_PER_SEC)) u_presc (
      .clk   (clk),
      .rst_n (rst_n),
      .tick  (tick),
      .run   (ctrl_run),
      .busy  (busy),
      .roll  (roll)
   );

   rtc_cal_next u_next (
      .cur       (cur),
      .nxt       (nxt),
      .wrap_sec  (ev_min),
      .wrap_min  (ev_hour),
      .wrap_hour (ev_day)
   );

   assign now_f[F_SEC]  = cur.sec;
   assign now_f[F_MIN]  = cur.min;
   assign now_f[F_HOUR] = cur.hour;
   assign now_f[F_DAY]  = cur.day;
   assign now_f[F_MON]  = cur.mon;
   assign now_f[F_YEAR] = cur.year;

   rtc_alarm_cmp #(.NF(NF)) u_cmp (
      .now_f (now_f),
      .alm_f (alm_f),
      .match (match)
   );

   assign hit_status = bus_we && (bus_addr == ADDR_W'(OFS_STATUS));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cur      <= TIME_RST;
         alm_f    <= '0;
         ctrl_run <= 1'b0;
         ie_alarm <= 1'b0;
         ie_timer <= 1'b0;
         st_pwr   <= 1'b1;
         st_alm   <= 1'b0;
         ev_q     <= '0;
         upd_q    <= 1'b0;
      end else begin
         upd_q <= roll;
         if (roll) begin
            cur  <= nxt;
            ev_q <= {ev_day, ev_hour, ev_min, 1'b1};
         end
         // a software write to a field takes precedence over the update
         if (bus_we) begin
            case (bus_addr)
               ADDR_W'(OFS_SEC):      cur.sec  <= bus_wdata;
               ADDR_W'(OFS_MIN):      cur.min  <= bus_wdata;
               ADDR_W'(OFS_HOUR):     cur.hour <= bus_wdata;
               ADDR_W'(OFS_DAY):      cur.day  <= bus_wdata;
               ADDR_W'(OFS_MON):      cur.mon  <= bus_wdata;
               ADDR_W'(OFS_YEAR):     cur.year <= bus_wdata;
               ADDR_W'(OFS_WDAY):     cur.wday <= bus_wdata[2:0];
               ADDR_W'(OFS_ALM_SEC):  alm_f[F_SEC]  <= bus_wdata;
               ADDR_W'(OFS_ALM_MIN):  alm_f[F_MIN]  <= bus_wdata;
               ADDR_W'(OFS_ALM_HOUR): alm_f[F_HOUR] <= bus_wdata;
               ADDR_W'(OFS_ALM_DAY):  alm_f[F_DAY]  <= bus_wdata;
               ADDR_W'(OFS_ALM_MON):  alm_f[F_MON]  <= bus_wdata;
               ADDR_W'(OFS_ALM_YEAR): alm_f[F_YEAR] <= bus_wdata;
               ADDR_W'(OFS_CTRL):     ctrl_run <= bus_wdata[0];
               ADDR_W'(OFS_IRQEN): begin
                  ie_alarm <= bus_wdata[3];
                  ie_timer <= bus_wdata[2];
               end
               default: ;
            endcase
         end
         st_pwr <= st_pwr & ~(hit_status & bus_wdata[7]);
         // a new match wins over a same-cycle clear
         st_alm <= (upd_q & match) | (st_alm & ~(hit_status & bus_wdata[6]));
      end
   end

   always_comb begin
      bus_rdata = 8'h00;
      case (bus_addr)
         ADDR_W'(OFS_SEC):      bus_rdata = cur.sec;
         ADDR_W'(OFS_MIN):      bus_rdata = cur.min;
         ADDR_W'(OFS_HOUR):     bus_rdata = cur.hour;
         ADDR_W'(OFS_DAY):      bus_rdata = cur.day;
         ADDR_W'(OFS_MON):      bus_rdata = cur.mon;
         ADDR_W'(OFS_YEAR):     bus_rdata = cur.year;
         ADDR_W'(OFS_WDAY):     bus_rdata = {5'd0, cur.wday};
         ADDR_W'(OFS_ALM_SEC):  bus_rdata = alm_f[F_SEC];
         ADDR_W'(OFS_ALM_MIN):  bus_rdata = alm_f[F_MIN];
         ADDR_W'(OFS_ALM_HOUR): bus_rdata = alm_f[F_HOUR];
         ADDR_W'(OFS_ALM_DAY):  bus_rdata = alm_f[F_DAY];
         ADDR_W'(OFS_ALM_MON):  bus_rdata = alm_f[F_MON];
         ADDR_W'(OFS_ALM_YEAR): bus_rdata = alm_f[F_YEAR];
         ADDR_W'(OFS_CTRL):     bus_rdata = {7'd0, ctrl_run};
         ADDR_W'(OFS_STATUS):   bus_rdata = {st_pwr, st_alm, ev_q, ctrl_run, busy};
         ADDR_W'(OFS_IRQEN):    bus_rdata = {4'd0, ie_alarm, ie_timer, 2'd0};
         default:               bus_rdata = 8'h00;
      endcase
   end

   assign irq_timer = upd_q & ie_timer;
   assign irq_alarm = st_alm & ie_alarm;

endmodule

// File: rtl/rtc_bcd_calendar_chk.sv
module rtc_bcd_calendar_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       tick,
   input logic       bus_we,
   input logic       run,
   input logic       upd_q,
   input logic       st_pwr,
   input logic       st_alm,
   input logic       irq_timer,
   input logic [7:0] sec
);

   // R2: a stopped clock with no write keeps its seconds
   p_frozen_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (!run && !bus_we) |=> $stable(sec));

   // R3: seconds move only on a tick when software did not write
   p_sec_on_tick_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (!$past(bus_we) && (sec != $past(sec))) |-> $past(tick));

   // R8: the alarm flag can only rise right after an update
   p_alarm_after_upd_r8: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(st_alm) |-> $past(upd_q));

   // R9: the power-up flag only drops through a bus write
   p_pwr_w1c_r9: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(st_pwr) |-> $past(bus_we));

   // R11: the timer interrupt is a single-clock pulse
   p_timer_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n)
      irq_timer |=> !irq_timer);

endmodule

bind rtc_bcd_calendar rtc_bcd_calendar_chk u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .tick      (tick),
   .bus_we    (bus_we),
   .run       (ctrl_run),
   .upd_q     (upd_q),
   .st_pwr    (st_pwr),
   .st_alm    (st_alm),
   .irq_timer (irq_timer),
   .sec       (cur.sec)
);

// File: tb/rtc_bcd_calendar_tb.sv
`timescale 1ns/1ps
module rtc_bcd_calendar_tb;

   localparam int unsigned TPS = 4;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       tick = 1'b0;
   logic [6:0] bus_addr = '0;
   logic       bus_we = 1'b0;
   logic [7:0] bus_wdata = '0;
   logic [7:0] bus_rdata;
   logic       irq_timer;
   logic       irq_alarm;

   int n_cmp = 0;
   int n_bad = 0;

   // reference calendar, binary
   int ms, mm, mh, md, mmo, my, mw;
   bit e_s, e_m, e_h, e_d;

   rtc_bcd_calendar #(.TICKS_PER_SEC(TPS), .ADDR_W(7)) u_dut (
      .clk       (clk),
      .rst_n     (rst_n),
      .tick      (tick),
      .bus_addr  (bus_addr),
      .bus_we    (bus_we),
      .bus_wdata (bus_wdata),
      .bus_rdata (bus_rdata),
      .irq_timer (irq_timer),
      .irq_alarm (irq_alarm)
   );

   always #10 clk = ~clk;

   function automatic logic [7:0] to_bcd(input int v);
      return 8'((v / 10) * 16 + (v % 10));
   endfunction

   function automatic int days_in(input int mo, input int y);
      if (mo == 2) return (y % 4 == 0) ? 29 : 28;
      if (mo == 4 || mo == 6 || mo == 9 || mo == 11) return 30;
      return 31;
   endfunction

   task automatic summary();
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
   endtask

   task automatic check8(input string req, input string what,
                         input logic [7:0] act, input logic [7:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s %s: actual %02h expected %02h", req, what, act, exp);
      end
   endtask

   task automatic wr(input logic [6:0] a, input logic [7:0] d);
      @(negedge clk);
      bus_addr  = a;
      bus_wdata = d;
      bus_we    = 1'b1;
      @(negedge clk);
      bus_we    = 1'b0;
   endtask

   task automatic rd(input logic [6:0] a, output logic [7:0] d);
      @(negedge clk);
      bus_addr = a;
      #1 d = bus_rdata;
   endtask

   task automatic give_ticks(input int n);
      for (int i = 0; i < n; i++) begin
         @(negedge clk) tick = 1'b1;
         @(negedge clk) tick = 1'b0;
      end
      #1;
   endtask

   task automatic model_step();
      e_s = 1; e_m = 0; e_h = 0; e_d = 0;
      ms++;
      if (ms == 60) begin
         ms = 0; e_m = 1; mm++;
         if (mm == 60) begin
            mm = 0; e_h = 1; mh++;
            if (mh == 24) begin
               mh = 0; e_d = 1; mw = (mw + 1) % 7; md++;
               if (md > days_in(mmo, my)) begin
                  md = 1; mmo++;
                  if (mmo == 13) begin
                     mmo = 1; my = (my + 1) % 100;
                  end
               end
            end
         end
      end
   endtask

   task automatic load_time();
      wr(7'h00, to_bcd(ms));
      wr(7'h04, to_bcd(mm));
      wr(7'h08, to_bcd(mh));
      wr(7'h0C, to_bcd(md));
      wr(7'h10, to_bcd(mmo));
      wr(7'h14, to_bcd(my));
      wr(7'h18, to_bcd(mw));
   endtask

   task automatic cmp_time();
      logic [7:0] v;
      rd(7'h00, v); check8("R4", "seconds", v, to_bcd(ms));
      rd(7'h04, v); check8("R4", "minutes", v, to_bcd(mm));
      rd(7'h08, v); check8("R4", "hours",   v, to_bcd(mh));
      rd(7'h0C, v); check8("R5", "day",     v, to_bcd(md));
      rd(7'h10, v); check8("R6", "month",   v, to_bcd(mmo));
      rd(7'h14, v); check8("R6", "year",    v, to_bcd(my));
      rd(7'h18, v); check8("R7", "weekday", v, to_bcd(mw));
   endtask

   task automatic set_alarm(input logic [7:0] s, input logic [7:0] mi,
                            input logic [7:0] h, input logic [7:0] d,
                            input logic [7:0] mo, input logic [7:0] y);
      wr(7'h20, s);
      wr(7'h24, mi);
      wr(7'h28, h);
      wr(7'h2C, d);
      wr(7'h30, mo);
      wr(7'h34, y);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: actual still running, expected finished");
      summary();
      $finish;
   end

   initial begin
      logic [7:0] v;
      logic [7:0] alm_v [6];
      int y;

      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 reset state
      ms = 0; mm = 0; mh = 0; md = 1; mmo = 1; my = 0; mw = 0;
      cmp_time();
      rd(7'h40, v); check8("R1", "control", v, 8'h00);
      rd(7'h44, v); check8("R1", "status", v, 8'h80);
      rd(7'h48, v); check8("R1", "irq enable", v, 8'h00);
      check8("R1", "irq pins", {6'd0, irq_timer, irq_alarm}, 8'h00);

      // R9 power-up flag: write 0 keeps it, write 1 clears it
      wr(7'h44, 8'h00);
      rd(7'h44, v); check8("R9", "power-up after write 0", v, 8'h80);
      wr(7'h44, 8'h80);
      rd(7'h44, v); check8("R9", "power-up after write 1", v, 8'h00);

      // R13 unmapped and misaligned addresses
      rd(7'h01, v); check8("R13", "read 0x01", v, 8'h00);
      rd(7'h1C, v); check8("R13", "read 0x1C", v, 8'h00);
      rd(7'h3C, v); check8("R13", "read 0x3C", v, 8'h00);
      wr(7'h21, 8'h55);
      wr(7'h02, 8'h33);
      rd(7'h20, v); check8("R13", "alarm sec after stray write", v, 8'h00);
      rd(7'h00, v); check8("R13", "sec after stray write", v, 8'h00);

      // R2 run bit, bit 7 reads 0
      wr(7'h40, 8'hFF);
      rd(7'h40, v); check8("R2", "control readback", v, 8'h01);
      rd(7'h44, v); check8("R2", "status running", v, 8'h02);
      wr(7'h40, 8'h00);
      give_ticks(8);
      rd(7'h00, v); check8("R2", "frozen seconds", v, 8'h00);
      rd(7'h44, v); check8("R2", "status stopped", v, 8'h00);

      // R3 busy window and one-second step
      wr(7'h40, 8'h01);
      give_ticks(TPS - 1);
      rd(7'h44, v); check8("R3", "busy before update", v, 8'h03);
      rd(7'h00, v); check8("R3", "sec before update", v, 8'h00);
      give_ticks(1);
      rd(7'h00, v); check8("R3", "sec after update", v, 8'h01);
      rd(7'h44, v); check8("R3", "status after update", v, 8'h06);
      ms = 1;

      // R4 R5 R7 R10 second-by-second sweep over a Feb/Mar boundary
      wr(7'h40, 8'h00);
      my = 3; mmo = 2; md = 28; mh = 23; mm = 58; ms = 0; mw = 6;
      load_time();
      wr(7'h40, 8'h01);
      for (int k = 0; k < 130; k++) begin
         give_ticks(TPS);
         model_step();
         cmp_time();
         rd(7'h44, v);
         check8("R10", "event flags", v & 8'h3C, {2'b00, e_d, e_h, e_m, e_s, 2'b00});
      end

      // R5 R6 month ends over leap and plain years, last day and day before
      for (int yi = 0; yi < 7; yi++) begin
         y = (yi < 5) ? yi : 93 + yi;
         for (int mo = 1; mo <= 12; mo++) begin
            for (int k = 0; k < 2; k++) begin
               wr(7'h40, 8'h00);
               my = y; mmo = mo; md = days_in(mo, y) - 1 + k;
               mh = 23; mm = 59; ms = 59; mw = (mo + k) % 7;
               load_time();
               wr(7'h40, 8'h01);
               give_ticks(TPS);
               model_step();
               cmp_time();
            end
         end
      end

      // R8 near misses in each single field, then a full match
      alm_v[0] = 8'h31; alm_v[1] = 8'h21; alm_v[2] = 8'h11;
      alm_v[3] = 8'h16; alm_v[4] = 8'h08; alm_v[5] = 8'h13;
      for (int f = 0; f <= 6; f++) begin
         wr(7'h40, 8'h00);
         my = 12; mmo = 7; md = 15; mh = 10; mm = 20; ms = 29; mw = 2;
         load_time();
         set_alarm((f == 0) ? alm_v[0] : 8'h30, (f == 1) ? alm_v[1] : 8'h20,
                   (f == 2) ? alm_v[2] : 8'h10, (f == 3) ? alm_v[3] : 8'h15,
                   (f == 4) ? alm_v[4] : 8'h07, (f == 5) ? alm_v[5] : 8'h12);
         wr(7'h40, 8'h01);
         give_ticks(TPS);
         @(negedge clk);
         rd(7'h44, v);
         if (f < 6) check8("R8", "near miss alarm flag", v & 8'h40, 8'h00);
         else       check8("R8", "full match alarm flag", v & 8'h40, 8'h40);
      end

      // R12 alarm interrupt gating
      check8("R12", "irq_alarm disabled", {7'd0, irq_alarm}, 8'h00);
      wr(7'h48, 8'h08);
      #1 check8("R12", "irq_alarm enabled", {7'd0, irq_alarm}, 8'h01);

      // R9 alarm flag write-one-to-clear
      wr(7'h44, 8'h00);
      rd(7'h44, v); check8("R9", "alarm after write 0", v & 8'h40, 8'h40);
      wr(7'h44, 8'h40);
      rd(7'h44, v); check8("R9", "alarm after write 1", v & 8'h40, 8'h00);
      #1 check8("R12", "irq_alarm after clear", {7'd0, irq_alarm}, 8'h00);

      // R11 timer pulse, R10 flag hold between updates
      wr(7'h48, 8'h04);
      give_ticks(TPS);
      check8("R11", "timer pulse high", {7'd0, irq_timer}, 8'h01);
      @(negedge clk);
      #1 check8("R11", "timer pulse one clock", {7'd0, irq_timer}, 8'h00);
      give_ticks(TPS / 2);
      rd(7'h44, v); check8("R10", "second flag held", v & 8'h04, 8'h04);
      give_ticks(TPS / 2);
      wr(7'h48, 8'h00);
      give_ticks(TPS);
      check8("R11", "timer masked", {7'd0, irq_timer}, 8'h00);
      wr(7'h40, 8'h00);
      wr(7'h48, 8'h04);
      give_ticks(TPS);
      check8("R11", "timer while stopped", {7'd0, irq_timer}, 8'h00);

      summary();
      $finish;
   end

endmodule